// File: doc/BRIEF.md
# Memory-Mapped Register Bank with Atomic Multi-Word Ports

This block sits between a processor's AXI4-Lite port and a compute core. Each core value is reached through 32-bit registers. A value wider than 32 bits, or a vector of such values, is split across consecutive word addresses. The lowest 32 bits of each element sit at the lowest address. Elements follow one another in index order.

Input values travel toward the core. Software writes the words of an input value into staging registers, and the core does not see them yet. Software then writes a command register that belongs to that value. All staged words move into the core-facing shadow register on the same clock edge, so the core never sees a half-updated value.

Output values travel the other way. A command write to an output's own command register takes a snapshot of every word of the core's value on one edge. Later reads return that coherent snapshot.

The bus side follows valid/ready rules. A write is taken only when the address and data channels are both valid in the same cycle. The block holds its write response until the master raises BREADY, and holds each read beat until RREADY. A master that keeps BREADY or RREADY low stalls further writes or reads. No request is dropped.

Top module: `regbank_axil`

## Requirements
- R1: A write completes when AWVALID and WVALID are high together. AWREADY and WREADY then rise in that same cycle. One write response with BRESP = 2'b00 follows in the next cycle and stays valid until BREADY. A read is accepted when ARVALID is high and no read beat is pending. Its beat, with RRESP = 2'b00, appears the next cycle and stays valid, with unchanged RDATA, until RREADY.
- R2: Word k of element e of an N-word port sits at base + 4·(e·N + k) and carries element bits 32k+31:32k. The default map is as follows. Inputs: 64-bit value at 0x100/0x104, 45-bit value at 0x110/0x114, three 64-bit elements at 0x120–0x134. Outputs: 64-bit value at 0x148/0x14C, 45-bit value at 0x158/0x15C, three 64-bit elements at 0x180–0x194.
- R3: A write to an input port's data words leaves that port's core-facing output unchanged.
- R4: Each input port has a command register: 0x108, 0x118 and 0x138. A write to it that has data bit 0 = 1 and byte lane 0 enabled moves every staged word to the core output together. The new value is visible the cycle after the write is accepted.
- R5: A command write with data bit 0 = 0 changes neither the core outputs nor the captured output snapshots.
- R6: Each output port has a command register: 0x150, 0x160 and 0x198. A write to it with bit 0 = 1 captures all words of the core's value on one edge. Reads of that port return the capture until the next capture, whatever the core input does.
- R7: After reset, each input port's staging words and core output hold a per-port parameter value, zero by default. Output snapshots read zero.
- R8: With readback enabled, a read of an input data word returns the last value written. Bits above the port width read 0, so the upper word of the 45-bit port shows only bits 12:0. Command register addresses read 0.
- R9: WSTRB bit b enables byte b of a data-word write. Disabled bytes keep their old value.
- R10: An address that no register decodes reads 0 with an OKAY response. A write to such an address is answered OKAY and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_a_o | output | IN_A_W | Committed wide input value A |
| core_b_o | output | IN_B_W | Committed wide input value B |
| core_v_o | output | VEC_N·VEC_W | Committed input vector, element 0 in the low bits |
| core_a_i | input | IN_A_W | Core output value A |
| core_b_i | input | IN_B_W | Core output value B |
| core_v_i | input | VEC_N·VEC_W | Core output vector, element 0 in the low bits |

## Verification
A staging word that leaks into the shadow before its command write shows up on the core output pins in the cycle after the data write. It is caught before any commit. A missed or partial commit leaves one element or word of the core output stale right after the command write is answered. Snapshot faults appear on the next read of an output word, once the core input has been changed. A wrong word or byte decode puts a value at the wrong address. The readback immediately after the write exposes it, or the core output exposes it one cycle after the next commit.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned LANES  = BUS_W / 8;
  localparam logic [1:0]  RESP_OK = 2'b00;

  function automatic int unsigned words_for(input int unsigned width);
    return (width + BUS_W - 1) / BUS_W;
  endfunction
endpackage

// File: rtl/axil_slv_ctrl.sv
module axil_slv_ctrl
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [LANES-1:0]  wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [BUS_W-1:0]  rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BUS_W-1:0]  wr_data,
  output logic [LANES-1:0]  wr_strb,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BUS_W-1:0]  rd_word
);
  logic bvalid_q, rvalid_q;
  logic [BUS_W-1:0] rdata_q;
  logic take_w, take_r;

  assign take_w  = awvalid && wvalid && !bvalid_q;
  assign take_r  = arvalid && !rvalid_q;
  assign awready = take_w;
  assign wready  = take_w;
  assign arready = !rvalid_q;
  assign bvalid  = bvalid_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;

  assign wr_en   = take_w;
  assign wr_addr = awaddr;
  assign wr_data = wdata;
  assign wr_strb = wstrb;
  assign rd_addr = araddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
    end else if (take_w) begin
      bvalid_q <= 1'b1;
    end else if (bready) begin
      bvalid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (take_r) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end

  // R1
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid_q && !bready |=> bvalid_q);
  // R1
  b_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && wvalid && awready |=> bvalid_q);
  // R1
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q && !rready |=> rvalid_q && $stable(rdata_q));
endmodule

// File: rtl/in_port_stage.sv
module in_port_stage
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned WIDTH    = 64,
  parameter int unsigned NELEM    = 1,
  parameter int unsigned BASE     = 'h100,
  parameter int unsigned CMD_ADDR = 'h108,
  parameter bit          READBACK = 1'b1,
  parameter logic [NELEM*WIDTH-1:0] INIT = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [BUS_W-1:0]       wr_data,
  input  logic [LANES-1:0]       wr_strb,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [BUS_W-1:0]       rd_data,
  output logic [NELEM*WIDTH-1:0] core_q
);
  localparam int unsigned WPE   = words_for(WIDTH);
  localparam int unsigned NW    = NELEM * WPE;
  localparam int unsigned IDX_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int unsigned NSLOT = 1 << IDX_W;

  function automatic logic [BUS_W-1:0] word_mask(input int unsigned i);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int b = 0; b < BUS_W; b++)
      if (BUS_W * (i % WPE) + b < WIDTH) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [BUS_W-1:0] init_word(input int unsigned i);
    logic [BUS_W-1:0] r;
    r = '0;
    for (int b = 0; b < BUS_W; b++)
      if (BUS_W * (i % WPE) + b < WIDTH)
        r[b] = INIT[(i / WPE) * WIDTH + BUS_W * (i % WPE) + b];
    return r;
  endfunction

  logic [NW*BUS_W-1:0]    stg_flat;
  logic [BUS_W-1:0]       stg_words [NSLOT];
  logic [NELEM*WIDTH-1:0] shadow_d;
  logic                   commit;

  for (genvar i = 0; i < NSLOT; i++) begin : g_word
    if (i < NW) begin : g_live
      localparam logic [BUS_W-1:0] MASK = word_mask(i);
      localparam logic [BUS_W-1:0] RST  = init_word(i);
      logic [BUS_W-1:0] stg_q;
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(BASE + 4 * i));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_q <= RST;
        end else if (hit) begin
          for (int b = 0; b < LANES; b++)
            if (wr_strb[b]) stg_q[8*b +: 8] <= wr_data[8*b +: 8] & MASK[8*b +: 8];
        end
      end
      assign stg_flat[BUS_W*i +: BUS_W] = stg_q;
      assign stg_words[i] = stg_q;
    end else begin : g_pad
      assign stg_words[i] = '0;
    end
  end

  for (genvar e = 0; e < NELEM; e++) begin : g_elem
    assign shadow_d[e*WIDTH +: WIDTH] = stg_flat[e*WPE*BUS_W +: WIDTH];
  end

  assign commit = wr_en && (wr_addr == ADDR_W'(CMD_ADDR)) && wr_strb[0] && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      core_q <= INIT;
    else if (commit) core_q <= shadow_d;
  end

  logic [ADDR_W-1:0] off;
  logic              in_rng;
  assign off    = rd_addr - ADDR_W'(BASE);
  assign in_rng = (rd_addr >= ADDR_W'(BASE)) && (off < ADDR_W'(4 * NW)) &&
                  (rd_addr[1:0] == 2'b00);
  assign rd_data = (READBACK && in_rng) ? stg_words[off[IDX_W+1:2]] : '0;

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(core_q));
endmodule

// File: rtl/out_port_stage.sv
module out_port_stage
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned WIDTH    = 64,
  parameter int unsigned NELEM    = 1,
  parameter int unsigned BASE     = 'h148,
  parameter int unsigned CMD_ADDR = 'h150
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic                   cmd_bit,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [BUS_W-1:0]       rd_data,
  input  logic [NELEM*WIDTH-1:0] core_d
);
  localparam int unsigned WPE   = words_for(WIDTH);
  localparam int unsigned NW    = NELEM * WPE;
  localparam int unsigned IDX_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int unsigned NSLOT = 1 << IDX_W;

  logic [NELEM*WIDTH-1:0] snap_q;
  logic [BUS_W-1:0]       snap_words [NSLOT];
  logic                   capture;

  assign capture = wr_en && (wr_addr == ADDR_W'(CMD_ADDR)) && cmd_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)       snap_q <= '0;
    else if (capture) snap_q <= core_d;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_word
    if (i < NW) begin : g_live
      localparam int unsigned E  = i / WPE;
      localparam int unsigned K  = i % WPE;
      localparam int unsigned LO = E * WIDTH + BUS_W * K;
      localparam int unsigned NB = (WIDTH - BUS_W * K > BUS_W) ? BUS_W : WIDTH - BUS_W * K;
      assign snap_words[i] = BUS_W'(snap_q[LO +: NB]);
    end else begin : g_pad
      assign snap_words[i] = '0;
    end
  end

  logic [ADDR_W-1:0] off;
  logic              in_rng;
  assign off    = rd_addr - ADDR_W'(BASE);
  assign in_rng = (rd_addr >= ADDR_W'(BASE)) && (off < ADDR_W'(4 * NW)) &&
                  (rd_addr[1:0] == 2'b00);
  assign rd_data = in_rng ? snap_words[off[IDX_W+1:2]] : '0;

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(snap_q));
endmodule

// File: rtl/regbank_axil.sv
module regbank_axil
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned IN_A_W     = 64,
  parameter int unsigned IN_B_W     = 45,
  parameter int unsigned VEC_W      = 64,
  parameter int unsigned VEC_N      = 3,
  parameter bit          READBACK   = 1'b1,
  parameter logic [IN_A_W-1:0]      INIT_A = '0,
  parameter logic [IN_B_W-1:0]      INIT_B = '0,
  parameter logic [VEC_N*VEC_W-1:0] INIT_V = '0,
  parameter int unsigned IN_A_BASE  = 'h100,
  parameter int unsigned IN_A_CMD   = 'h108,
  parameter int unsigned IN_B_BASE  = 'h110,
  parameter int unsigned IN_B_CMD   = 'h118,
  parameter int unsigned IN_V_BASE  = 'h120,
  parameter int unsigned IN_V_CMD   = 'h138,
  parameter int unsigned OUT_A_BASE = 'h148,
  parameter int unsigned OUT_A_CMD  = 'h150,
  parameter int unsigned OUT_B_BASE = 'h158,
  parameter int unsigned OUT_B_CMD  = 'h160,
  parameter int unsigned OUT_V_BASE = 'h180,
  parameter int unsigned OUT_V_CMD  = 'h198
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      s_awaddr,
  input  logic                   s_awvalid,
  output logic                   s_awready,
  input  logic [31:0]            s_wdata,
  input  logic [3:0]             s_wstrb,
  input  logic                   s_wvalid,
  output logic                   s_wready,
  output logic [1:0]             s_bresp,
  output logic                   s_bvalid,
  input  logic                   s_bready,
  input  logic [ADDR_W-1:0]      s_araddr,
  input  logic                   s_arvalid,
  output logic                   s_arready,
  output logic [31:0]            s_rdata,
  output logic [1:0]             s_rresp,
  output logic                   s_rvalid,
  input  logic                   s_rready,
  output logic [IN_A_W-1:0]      core_a_o,
  output logic [IN_B_W-1:0]      core_b_o,
  output logic [VEC_N*VEC_W-1:0] core_v_o,
  input  logic [IN_A_W-1:0]      core_a_i,
  input  logic [IN_B_W-1:0]      core_b_i,
  input  logic [VEC_N*VEC_W-1:0] core_v_i
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BUS_W-1:0]  wr_data, rd_word;
  logic [LANES-1:0]  wr_strb;
  logic              cmd_bit;
  logic [BUS_W-1:0]  rd_ia, rd_ib, rd_iv, rd_oa, rd_ob, rd_ov;

  assign s_bresp = RESP_OK;
  assign s_rresp = RESP_OK;
  assign cmd_bit = wr_strb[0] && wr_data[0];
  assign rd_word = rd_ia | rd_ib | rd_iv | rd_oa | rd_ob | rd_ov;

  axil_slv_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  in_port_stage #(.ADDR_W(ADDR_W), .WIDTH(IN_A_W), .NELEM(1), .BASE(IN_A_BASE),
    .CMD_ADDR(IN_A_CMD), .READBACK(READBACK), .INIT(INIT_A)) u_in_a (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .rd_addr(rd_addr), .rd_data(rd_ia), .core_q(core_a_o));

  in_port_stage #(.ADDR_W(ADDR_W), .WIDTH(IN_B_W), .NELEM(1), .BASE(IN_B_BASE),
    .CMD_ADDR(IN_B_CMD), .READBACK(READBACK), .INIT(INIT_B)) u_in_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .rd_addr(rd_addr), .rd_data(rd_ib), .core_q(core_b_o));

  in_port_stage #(.ADDR_W(ADDR_W), .WIDTH(VEC_W), .NELEM(VEC_N), .BASE(IN_V_BASE),
    .CMD_ADDR(IN_V_CMD), .READBACK(READBACK), .INIT(INIT_V)) u_in_v (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .rd_addr(rd_addr), .rd_data(rd_iv), .core_q(core_v_o));

  out_port_stage #(.ADDR_W(ADDR_W), .WIDTH(IN_A_W), .NELEM(1), .BASE(OUT_A_BASE),
    .CMD_ADDR(OUT_A_CMD)) u_out_a (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .cmd_bit(cmd_bit),
    .rd_addr(rd_addr), .rd_data(rd_oa), .core_d(core_a_i));

  out_port_stage #(.ADDR_W(ADDR_W), .WIDTH(IN_B_W), .NELEM(1), .BASE(OUT_B_BASE),
    .CMD_ADDR(OUT_B_CMD)) u_out_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .cmd_bit(cmd_bit),
    .rd_addr(rd_addr), .rd_data(rd_ob), .core_d(core_b_i));

  out_port_stage #(.ADDR_W(ADDR_W), .WIDTH(VEC_W), .NELEM(VEC_N), .BASE(OUT_V_BASE),
    .CMD_ADDR(OUT_V_CMD)) u_out_v (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .cmd_bit(cmd_bit),
    .rd_addr(rd_addr), .rd_data(rd_ov), .core_d(core_v_i));
endmodule

// File: tb/test_regbank_axil.sv
module test_regbank_axil;
  localparam logic [63:0] INIT_A = 64'h0000_0005_0000_0007;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0]  awaddr = '0, araddr = '0;
  logic         awvalid = 0, wvalid = 0, arvalid = 0, bready = 1, rready = 0;
  logic [31:0]  wdata = '0;
  logic [3:0]   wstrb = '0;
  logic         awready, wready, bvalid, arready, rvalid;
  logic [1:0]   bresp, rresp;
  logic [31:0]  rdata;
  logic [63:0]  core_a_o, core_a_i = '0;
  logic [44:0]  core_b_o, core_b_i = '0;
  logic [191:0] core_v_o, core_v_i = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  regbank_axil #(.INIT_A(INIT_A)) i_regbank_axil (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .core_a_o(core_a_o), .core_b_o(core_b_o), .core_v_o(core_v_o),
    .core_a_i(core_a_i), .core_b_i(core_b_i), .core_v_i(core_v_i));

  task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic axi_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    #1;
    chk("R1 aw/w ready", {awready, wready}, 2'b11);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk("R1 write response", {bvalid, bresp}, 3'b100);
    @(negedge clk);
  endtask

  task automatic axi_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1; rready = 0;
    @(negedge clk);
    arvalid = 0;
    chk("R1 read beat", {rvalid, rresp}, 3'b100);
    d = rdata;
    @(negedge clk);
    chk("R1 read hold", {rvalid, rdata}, {1'b1, d});
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    axi_read(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R7 core A init", core_a_o, INIT_A);
    chk("R7 core B zero", core_b_o, '0);
    chk("R7 core V zero", core_v_o, '0);
    rd_chk("R7 staging A init", 12'h104, 32'h0000_0005);
    rd_chk("R7 snapshot zero", 12'h148, 32'h0);
  endtask

  task automatic t_in_a;
    axi_write(12'h100, 32'hCAFE_F00D, 4'hF);
    axi_write(12'h104, 32'h1234_5678, 4'hF);
    chk("R3 A before commit", core_a_o, INIT_A);
    axi_write(12'h108, 32'h0000_0002, 4'hF);
    chk("R5 A bit0 clear", core_a_o, INIT_A);
    axi_write(12'h108, 32'h0000_0001, 4'hF);
    chk("R4 A commit", core_a_o, 64'h1234_5678_CAFE_F00D);
    rd_chk("R8 readback A low", 12'h100, 32'hCAFE_F00D);
  endtask

  task automatic t_vec;
    logic [191:0] exp;
    for (int i = 0; i < 6; i++) begin
      axi_write(12'h120 + 12'(4 * i), 32'hA000_0000 + 32'(i), 4'hF);
      exp[32*i +: 32] = 32'hA000_0000 + 32'(i);
    end
    chk("R3 vector before commit", core_v_o, '0);
    axi_write(12'h138, 32'h1, 4'hF);
    chk("R2 R4 vector commit", core_v_o, exp);
  endtask

  task automatic t_in_b;
    axi_write(12'h110, 32'h89AB_CDEF, 4'hF);
    axi_write(12'h114, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R8 45-bit upper mask", 12'h114, 32'h0000_1FFF);
    axi_write(12'h118, 32'h1, 4'hF);
    chk("R2 45-bit commit", core_b_o, 45'h1FFF_89AB_CDEF);
    axi_write(12'h110, 32'hAABB_CCDD, 4'b0101);
    rd_chk("R9 byte lanes", 12'h110, 32'h89BB_CDDD);
    chk("R3 B held", core_b_o, 45'h1FFF_89AB_CDEF);
  endtask

  task automatic t_out;
    core_a_i = 64'h1111_2222_3333_4444;
    core_b_i = 45'h1ABC_DEAD_BEEF;
    for (int e = 0; e < 3; e++) core_v_i[64*e +: 64] = {32'hB100_0000 + 32'(e), 32'hB000_0000 + 32'(e)};
    axi_write(12'h150, 32'h1, 4'hF);
    axi_write(12'h160, 32'h1, 4'hF);
    axi_write(12'h198, 32'h1, 4'hF);
    core_a_i = ~core_a_i; core_b_i = ~core_b_i; core_v_i = ~core_v_i;
    axi_write(12'h150, 32'h0, 4'hF);
    rd_chk("R6 R5 out A low", 12'h148, 32'h3333_4444);
    rd_chk("R6 out A high", 12'h14C, 32'h1111_2222);
    rd_chk("R6 out B low", 12'h158, 32'hDEAD_BEEF);
    rd_chk("R6 out B high", 12'h15C, 32'h0000_1ABC);
    for (int e = 0; e < 3; e++) begin
      rd_chk("R6 R2 out vec low", 12'h180 + 12'(8 * e), 32'hB000_0000 + 32'(e));
      rd_chk("R6 R2 out vec high", 12'h184 + 12'(8 * e), 32'hB100_0000 + 32'(e));
    end
  endtask

  task automatic t_unmapped;
    axi_write(12'h200, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R10 unmapped read", 12'h200, 32'h0);
    rd_chk("R10 gap read", 12'h13C, 32'h0);
    rd_chk("R8 command reads zero", 12'h108, 32'h0);
    chk("R10 no side effect", core_a_o, 64'h1234_5678_CAFE_F00D);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_in_a();
    t_vec();
    t_in_b();
    t_out();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule